// File: doc/BRIEF.md
# Ethernet MAC Enable and Sleep Control

This block holds the five-bit control word of an Ethernet MAC and turns it into the enable, reset and sleep signals used by the transmit, receive, DMA and FIFO logic. Software writes the whole word at once. Hardware changes the word on its own in two cases. A software reset request clears every field one cycle after it is written. A bus error drops the MAC enable bit.

When the MAC enable bit falls, the receive enable drops in the same cycle. The DMA, descriptor and FIFO pointer logic is held in reset for as long as the bit stays low. If a frame is being sent at that moment, a one-cycle request asks the transmitter to end it with a corrupted CRC and to skip the descriptor write-back. With sleep and magic-packet enable both set, a detection pulse from the receive path sets a sticky wakeup flag. A bus error sets a second sticky flag. Each flag is cleared by writing 1 to its bit.

Top module: `macctl_top`

## Requirements
- R1: The control word reads back on `ctl_q` with the reset request at bit 0, sleep at bit 1, magic-packet enable at bit 2, MAC enable at bit 3 and timestamp enable at bit 4. After reset all bits, both flags and `mac_rst_o` are 0.
- R2: A write with bit 0 clear loads `ctl_wdata` into the word on the next clock edge.
- R3: A write with bit 0 set loads the other written fields but forces MAC enable to 0, and bit 0 reads 1 for exactly one cycle. In that cycle `mac_rst_o` is 1. On the next edge every field returns to 0.
- R4: A write presented in the cycle in which bit 0 reads 1 is discarded.
- R5: A `bus_err_i` pulse clears MAC enable on the next edge, even if a write in the same cycle sets it, and sets the bus-error flag (flag bit 1).
- R6: `rx_en_o` and `tx_en_o` equal the MAC enable bit. `dma_fifo_rst_o` is 1 whenever MAC enable is 0.
- R7: In the cycle after MAC enable falls, for any cause, `crc_abort_o` is 1 for that single cycle if `tx_busy_i` is 1, and it stays 0 otherwise.
- R8: `magic_arm_o` is 1 only when sleep and magic-packet enable are both 1. A `magic_det_i` pulse sets the wakeup flag (flag bit 0) only while armed.
- R9: `ts_en_o` follows bit 4 and `sleep_o` follows bit 1.
- R10: Each flag stays set until a write of `flag_clr` with 1 in its position. A 0 in a position leaves that flag unchanged, and a set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write value |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Write-1-to-clear mask (bit 0 wakeup, bit 1 bus error) |
| bus_err_i | input | 1 | Bus error event pulse |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| magic_det_i | input | 1 | Magic packet detected pulse |
| ctl_q | output | 5 | Current control word |
| flags_q | output | 2 | Sticky flags (bit 0 wakeup, bit 1 bus error) |
| mac_rst_o | output | 1 | One-cycle MAC reset pulse |
| rx_en_o | output | 1 | Receive enable |
| tx_en_o | output | 1 | Transmit enable |
| dma_fifo_rst_o | output | 1 | DMA, descriptor and FIFO pointer reset |
| crc_abort_o | output | 1 | End current frame with bad CRC, no descriptor update |
| ts_en_o | output | 1 | Timestamp enable to DMA |
| sleep_o | output | 1 | Sleep mode |
| magic_arm_o | output | 1 | Magic-packet detection active |

## Verification
On every cycle the assertions check that a bus error kills the enable, that the reset bit self-clears into an all-zero word, that the abort request never lasts more than a cycle, that the pointer reset covers every disabled cycle, and that the flags stay sticky and set only when qualified. The bench scenarios carry the rest. They sweep all 32 write values and all four sleep and magic combinations. They run the abort under each disable cause with the transmitter both busy and idle. They also cover the discarded write and the case where set and clear arrive in the same cycle, which need known stimulus to tell a right value from a wrong one.

// File: rtl/macctl_pkg.sv
package macctl_pkg;
  localparam int CTL_W  = 5;
  localparam int RST_B  = 0;
  localparam int SLP_B  = 1;
  localparam int MGC_B  = 2;
  localparam int ENA_B  = 3;
  localparam int TSE_B  = 4;
  localparam int FLG_W  = 2;
  localparam int WAKE_F = 0;
  localparam int BERR_F = 1;
  localparam logic [CTL_W-1:0] CTL_RESET = '0;
endpackage

// File: rtl/macctl_fields.sv
module macctl_fields
  import macctl_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         bus_err,
  output logic [W-1:0] ctl_q
);
  logic [W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) begin
      ctl_d = wdata;
      if (wdata[RST_B]) ctl_d[ENA_B] = 1'b0;
    end
    if (bus_err) ctl_d[ENA_B] = 1'b0;
    if (ctl_q[RST_B]) ctl_d = CTL_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/macctl_abort.sv
module macctl_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tx_busy,
  output logic abort
);
  logic en_d1_q;
  logic en_d1_d;

  assign en_d1_d = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d1_q <= 1'b0;
    else        en_d1_q <= en_d1_d;
  end

  assign abort = en_d1_q & ~en & tx_busy;
endmodule

// File: rtl/macctl_flags.sv
module macctl_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic fl_d;
    logic fl_en;
    assign fl_en = set_ev[i] | (clr_we & clr_mask[i]);
    assign fl_d  = set_ev[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q[i] <= 1'b0;
      else if (fl_en) flag_q[i] <= fl_d;
    end
  end
endmodule

// File: rtl/macctl_top.sv
module macctl_top
  import macctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             flag_clr_we,
  input  logic [FLG_W-1:0] flag_clr,
  input  logic             bus_err_i,
  input  logic             tx_busy_i,
  input  logic             magic_det_i,
  output logic [CTL_W-1:0] ctl_q,
  output logic [FLG_W-1:0] flags_q,
  output logic             mac_rst_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             dma_fifo_rst_o,
  output logic             crc_abort_o,
  output logic             ts_en_o,
  output logic             sleep_o,
  output logic             magic_arm_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [FLG_W-1:0] set_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  macctl_fields #(.W(CTL_W)) u_fields (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .bus_err (bus_err_i),
    .ctl_q   (ctl_q)
  );

  macctl_abort u_abort (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (ctl_q[ENA_B]),
    .tx_busy (tx_busy_i),
    .abort   (crc_abort_o)
  );

  assign magic_arm_o    = ctl_q[SLP_B] & ctl_q[MGC_B];
  assign set_ev[WAKE_F] = magic_det_i & magic_arm_o;
  assign set_ev[BERR_F] = bus_err_i;

  macctl_flags #(.N(FLG_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_ev   (set_ev),
    .clr_we   (flag_clr_we),
    .clr_mask (flag_clr),
    .flag_q   (flags_q)
  );

  assign mac_rst_o      = ctl_q[RST_B];
  assign rx_en_o        = ctl_q[ENA_B];
  assign tx_en_o        = ctl_q[ENA_B];
  assign dma_fifo_rst_o = ~ctl_q[ENA_B];
  assign ts_en_o        = ctl_q[TSE_B];
  assign sleep_o        = ctl_q[SLP_B];
endmodule

// File: rtl/macctl_chk.sv
module macctl_chk
  import macctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             flag_clr_we,
  input logic [FLG_W-1:0] flag_clr,
  input logic             bus_err_i,
  input logic             tx_busy_i,
  input logic             magic_det_i,
  input logic [CTL_W-1:0] ctl_q,
  input logic [FLG_W-1:0] flags_q,
  input logic             mac_rst_o,
  input logic             rx_en_o,
  input logic             tx_en_o,
  input logic             dma_fifo_rst_o,
  input logic             crc_abort_o,
  input logic             ts_en_o,
  input logic             sleep_o,
  input logic             magic_arm_o
);
  // R5
  berr_kills_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> !rx_en_o && flags_q[BERR_F]);

  // R3
  rst_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rst_o |=> (ctl_q == CTL_RESET));

  // R7
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_abort_o |=> !crc_abort_o);

  // R7
  abort_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_abort_o |-> tx_busy_i && !tx_en_o);

  // R6
  ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_o |-> dma_fifo_rst_o);

  // R8
  wake_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[WAKE_F] && !(magic_det_i && magic_arm_o)) |=> !flags_q[WAKE_F]);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[WAKE_F] && !(flag_clr_we && flag_clr[WAKE_F])) |=> flags_q[WAKE_F]);
endmodule

bind macctl_top macctl_chk u_chk (.*);

// File: tb/sim_macctl_top.sv
`timescale 1ns/1ps
module sim_macctl_top;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       flag_clr_we = 1'b0;
  logic [1:0] flag_clr = '0;
  logic       bus_err_i = 1'b0;
  logic       tx_busy_i = 1'b0;
  logic       magic_det_i = 1'b0;
  logic [4:0] ctl_q;
  logic [1:0] flags_q;
  logic mac_rst_o, rx_en_o, tx_en_o, dma_fifo_rst_o, crc_abort_o;
  logic ts_en_o, sleep_o, magic_arm_o;

  int total = 0;
  int bad = 0;

  always #(HALF) clk = ~clk;

  macctl_top u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0; flag_clr_we = 1'b0; bus_err_i = 1'b0; magic_det_i = 1'b0;
  endtask

  task automatic wr(logic [4:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
  endtask

  task automatic clr(logic [1:0] m);
    flag_clr_we = 1'b1; flag_clr = m;
    step();
  endtask

  task automatic done();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset word", ctl_q, 0);
    check("R1 reset flags", flags_q, 0);
    check("R1 reset pulse", mac_rst_o, 0);
    check("R6 reset ptr rst", dma_fifo_rst_o, 1);

    // sweep all write values
    for (int v = 0; v < 32; v++) begin
      logic [4:0] e;
      e = v[4:0];
      if (v[0]) e[3] = 1'b0;
      wr(v[4:0]);
      check(v[0] ? "R3 write with reset" : "R2 write", ctl_q, e);
      check("R3 reset pulse", mac_rst_o, v[0]);
      check("R6 rx en", rx_en_o, e[3]);
      check("R6 tx en", tx_en_o, e[3]);
      check("R6 ptr rst", dma_fifo_rst_o, !e[3]);
      check("R9 ts en", ts_en_o, e[4]);
      check("R9 sleep", sleep_o, e[1]);
      check("R8 arm", magic_arm_o, e[1] & e[2]);
      if (v[0]) begin
        step();
        check("R3 cleared after reset", ctl_q, 0);
        check("R3 pulse ends", mac_rst_o, 0);
      end
      wr(5'd0);
      check("R7 no abort when idle", crc_abort_o, 0);
    end

    // R4: write during reset cycle discarded
    wr(5'b00001);
    wr(5'b10110);
    check("R4 discarded write", ctl_q, 0);

    // R5 bus error with and without concurrent enabling write
    wr(5'b01000);
    bus_err_i = 1'b1; step();
    check("R5 en cleared", ctl_q[3], 0);
    check("R5 flag set", flags_q, 2'b10);
    clr(2'b01);
    check("R10 other flag untouched", flags_q, 2'b10);
    clr(2'b10);
    check("R10 flag cleared", flags_q, 2'b00);
    ctl_we = 1'b1; ctl_wdata = 5'b01000; bus_err_i = 1'b1; step();
    check("R5 err beats write", ctl_q[3], 0);
    bus_err_i = 1'b1; flag_clr_we = 1'b1; flag_clr = 2'b10; step();
    check("R10 set wins", flags_q[1], 1);
    clr(2'b11);

    // R7 abort under each disable cause, busy and idle
    for (int cause = 0; cause < 3; cause++) begin
      for (int b = 0; b < 2; b++) begin
        wr(5'b01000);
        tx_busy_i = b[0];
        if (cause == 0) begin ctl_we = 1'b1; ctl_wdata = 5'b00000; end
        else if (cause == 1) bus_err_i = 1'b1;
        else begin ctl_we = 1'b1; ctl_wdata = 5'b01001; end
        step();
        check("R7 abort on fall", crc_abort_o, b[0]);
        step();
        check("R7 abort one cycle", crc_abort_o, 0);
        tx_busy_i = 1'b0;
        clr(2'b11);
      end
    end

    // R8 wakeup sweep over sleep and magic enable
    for (int s = 0; s < 4; s++) begin
      wr({2'b00, s[1], s[0], 1'b0});
      magic_det_i = 1'b1; step();
      check("R8 wakeup", flags_q[0], s[0] & s[1]);
      step();
      check("R10 wake sticky", flags_q[0], s[0] & s[1]);
      clr(2'b01);
      check("R10 wake cleared", flags_q[0], 0);
    end

    done();
  end
endmodule